// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Protect Arbiter

This block keeps the status byte of a serial EEPROM and decides, for each incoming command, whether a write to the memory array or to the status register may go ahead. It holds three nonvolatile-style bits: a protection enable and a two-bit block-protect code. It also holds a volatile write-enable latch. It takes the current busy flag from the page sequencer, and it keeps a sample of the write-protect pin taken when a status-write op-code completes.

The page sequencer reads two combinational permission flags for each command. One covers an array write to the presented address and the other covers a status write. When a programming cycle finishes, the sequencer pulses a commit strobe. A status commit loads the protection bits from the data byte. Either kind of commit drops the write-enable latch. The sequencer owns all cycle timing. This block only records and judges.

Top module: `wp_status_arbiter`

## Requirements
- R1: After a synchronous reset the write-enable latch, the protection enable and both block-protect bits are 0, and while not busy the status byte reads 8'h00 with both permission flags low.
- R2: While busy_i is low, a wren_i pulse sets the write-enable latch and a wrdi_i pulse clears it. When both arrive in the same cycle the clear wins. While busy_i is high, wren_i has no effect.
- R3: With the write-enable latch at 0, both arr_wr_ok_o and sr_wr_ok_o are 0.
- R4: sr_wr_ok_o is 1 exactly when the latch is 1, busy_i is 0, and either the protection enable is 0 or the write-protect level sampled at the last sr_opcode_done_i pulse was high. A change on wp_pin_i after that pulse does not alter sr_wr_ok_o.
- R5: arr_wr_ok_o is 1 exactly when the latch is 1, busy_i is 0, and addr_i lies outside the protected range. The range is set by the block-protect code (status bit3 = high bit, bit2 = low bit), for the default 13-bit address: 00 protects nothing, 01 protects 1800h–1FFFh, 10 protects 1000h–1FFFh, 11 protects 0000h–1FFFh. Only the top two address bits decide, so a 32-byte page is never split.
- R6: A sr_commit_i pulse loads the protection enable from sr_data_i bit7 and the block-protect code from bits 3:2, ignores all other data bits, and clears the latch. Without that pulse these three bits never change.
- R7: An arr_commit_i pulse clears the latch and leaves the protection bits unchanged. A commit clear wins over a same-cycle wren_i.
- R8: The status byte is bit7 = protection enable, bits 6:4 = 0, bit3/bit2 = block-protect code, bit1 = write-enable latch, bit0 = busy_i. While busy_i is high it reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin_i | input | 1 | Write-protect pin level (1 = not protecting) |
| wren_i | input | 1 | Write-enable request pulse |
| wrdi_i | input | 1 | Write-disable request pulse |
| sr_opcode_done_i | input | 1 | Status-write op-code just completed; samples wp_pin_i |
| sr_data_i | input | 8 | Data byte of the status write |
| sr_commit_i | input | 1 | Status programming cycle finished |
| arr_commit_i | input | 1 | Array programming cycle finished |
| addr_i | input | ADDR_W | Target byte address of the array write |
| busy_i | input | 1 | Programming cycle in progress |
| status_o | output | 8 | Status byte for the read-status command |
| arr_wr_ok_o | output | 1 | Array write to addr_i permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
The sweep goes through every block-protect code, every protection-enable value and both sampled pin levels. For each combination it probes every page, with an offset that moves inside each page. A design with an off-by-one range decode or a wrong code-to-range mapping would grant or refuse writes at the quarter and half boundaries 1000h and 1800h. A pin that is read live instead of sampled would let a late pin change flip status-write permission. The bench also aims at the priority collisions: set against clear, and set against commit. A reversed priority would leave writes enabled after a cycle. It also checks the busy override, where a design that forgot it would return the normal status byte instead of all ones, or would still grant writes. It also checks that the data bits outside 7 and 3:2 are dropped, since a design that loaded them would show nonzero bits 6:4.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

    typedef struct packed {
        logic       prot_en;
        logic [1:0] blk_code;
    } nv_bits_t;

    localparam logic [7:0] BUSY_VIEW = 8'hFF;

    // Decide whether an address region (its two top bits) is locked.
    function automatic logic region_locked(input logic [1:0] code,
                                           input logic [1:0] top2);
        logic hit;
        unique case (code)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (top2 == 2'b11);
            2'b10:   hit = top2[1];
            default: hit = 1'b1;
        endcase
        return hit;
    endfunction

    function automatic logic [7:0] status_view(input nv_bits_t nv,
                                               input logic wen,
                                               input logic busy);
        logic [7:0] v;
        if (busy) v = BUSY_VIEW;
        else      v = {nv.prot_en, 3'b000, nv.blk_code, wen, 1'b0};
        return v;
    endfunction

endpackage

// File: rtl/wpa_wen_latch.sv
module wpa_wen_latch (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic done_i,
    output logic wen_o
);
    logic wen_q;

    always_ff @(posedge clk) begin
        if (rst)                  wen_q <= 1'b0;
        else if (done_i || clr_i) wen_q <= 1'b0;
        else if (set_i && !busy_i) wen_q <= 1'b1;
    end

    assign wen_o = wen_q;

    a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
        (set_i && !busy_i && !clr_i && !done_i) |=> wen_o);
    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !wen_o);
    a_r2_busy_blocks_set: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !wen_o) |=> !wen_o);
    a_r7_commit_drops: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !wen_o);
endmodule

// File: rtl/wpa_nv_store.sv
module wpa_nv_store
    import wpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       commit_i,
    input  logic [7:0] wdata_i,
    input  logic       sample_i,
    input  logic       wp_pin_i,
    output nv_bits_t   nv_o,
    output logic       wp_seen_o
);
    nv_bits_t nv_q;
    logic     wp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_q <= '0;
            wp_q <= 1'b0;
        end else begin
            if (commit_i) begin
                nv_q.prot_en  <= wdata_i[7];
                nv_q.blk_code <= wdata_i[3:2];
            end
            if (sample_i) wp_q <= wp_pin_i;
        end
    end

    assign nv_o      = nv_q;
    assign wp_seen_o = wp_q;

    a_r6_hold_without_commit: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> $stable(nv_o));
    a_r6_load_on_commit: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> (nv_o.prot_en == $past(wdata_i[7])) &&
                     (nv_o.blk_code == $past(wdata_i[3:2])));
    a_r4_sample_held: assert property (@(posedge clk) disable iff (rst)
        !sample_i |=> $stable(wp_seen_o));
endmodule

// File: rtl/wpa_gate.sv
module wpa_gate
    import wpa_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              wen_i,
    input  logic              busy_i,
    input  nv_bits_t          nv_i,
    input  logic              wp_seen_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              arr_ok_o,
    output logic              sr_ok_o
);
    localparam int TOP = ADDR_W - 1;

    logic open_cmd;
    logic locked;
    logic sr_guard;

    always_comb begin
        open_cmd = wen_i && !busy_i;
        locked   = region_locked(nv_i.blk_code, addr_i[TOP -: 2]);
        sr_guard = nv_i.prot_en && !wp_seen_i;
        arr_ok_o = open_cmd && !locked;
        sr_ok_o  = open_cmd && !sr_guard;
    end
endmodule

// File: rtl/wp_status_arbiter.sv
module wp_status_arbiter
    import wpa_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_pin_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              sr_opcode_done_i,
    input  logic [7:0]        sr_data_i,
    input  logic              sr_commit_i,
    input  logic              arr_commit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_i,
    output logic [7:0]        status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    logic     wen;
    nv_bits_t nv;
    logic     wp_seen;
    logic     any_commit;

    assign any_commit = sr_commit_i || arr_commit_i;

    wpa_wen_latch u_wen (
        .clk    (clk),
        .rst    (rst),
        .busy_i (busy_i),
        .set_i  (wren_i),
        .clr_i  (wrdi_i),
        .done_i (any_commit),
        .wen_o  (wen)
    );

    wpa_nv_store u_nv (
        .clk       (clk),
        .rst       (rst),
        .commit_i  (sr_commit_i),
        .wdata_i   (sr_data_i),
        .sample_i  (sr_opcode_done_i),
        .wp_pin_i  (wp_pin_i),
        .nv_o      (nv),
        .wp_seen_o (wp_seen)
    );

    wpa_gate #(.ADDR_W(ADDR_W)) u_gate (
        .wen_i     (wen),
        .busy_i    (busy_i),
        .nv_i      (nv),
        .wp_seen_i (wp_seen),
        .addr_i    (addr_i),
        .arr_ok_o  (arr_wr_ok_o),
        .sr_ok_o   (sr_wr_ok_o)
    );

    assign status_o = status_view(nv, wen, busy_i);

    a_r3_no_latch_no_write: assert property (@(posedge clk) disable iff (rst)
        !status_o[1] && !busy_i |-> !arr_wr_ok_o && !sr_wr_ok_o);
    a_r5_full_lock: assert property (@(posedge clk) disable iff (rst)
        (status_o[3:2] == 2'b11 && !busy_i) |-> !arr_wr_ok_o);
    a_r8_busy_view: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (status_o == 8'hFF) && !arr_wr_ok_o && !sr_wr_ok_o);
    a_r8_spare_bits_zero: assert property (@(posedge clk) disable iff (rst)
        !busy_i |-> status_o[6:4] == 3'b000 && !status_o[0]);
endmodule

// File: tb/wp_status_arbiter_tb_top.sv
module wp_status_arbiter_tb_top;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst;
    logic          wp_pin_i, wren_i, wrdi_i, sr_opcode_done_i;
    logic [7:0]    sr_data_i;
    logic          sr_commit_i, arr_commit_i, busy_i;
    logic [AW-1:0] addr_i;
    logic [7:0]    status_o;
    logic          arr_wr_ok_o, sr_wr_ok_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    wp_status_arbiter #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .wp_pin_i(wp_pin_i), .wren_i(wren_i),
        .wrdi_i(wrdi_i), .sr_opcode_done_i(sr_opcode_done_i),
        .sr_data_i(sr_data_i), .sr_commit_i(sr_commit_i),
        .arr_commit_i(arr_commit_i), .addr_i(addr_i), .busy_i(busy_i),
        .status_o(status_o), .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic pulse_wren;  wren_i = 1; tick(); wren_i = 0; #1; endtask
    task automatic pulse_wrdi;  wrdi_i = 1; tick(); wrdi_i = 0; #1; endtask
    task automatic pulse_sample(input logic lvl);
        wp_pin_i = lvl; sr_opcode_done_i = 1; tick(); sr_opcode_done_i = 0; #1;
    endtask
    task automatic pulse_sr(input logic [7:0] d);
        sr_data_i = d; sr_commit_i = 1; tick(); sr_commit_i = 0; sr_data_i = 0; #1;
    endtask

    function automatic int expect_arr(input int code, input int a);
        int lim;
        case (code)
            0: lim = 8192;
            1: lim = 6144;
            2: lim = 4096;
            default: lim = 0;
        endcase
        return (a >= lim) ? 0 : 1;
    endfunction

    initial begin
        #150000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1; wp_pin_i = 1; wren_i = 0; wrdi_i = 0; sr_opcode_done_i = 0;
        sr_data_i = 0; sr_commit_i = 0; arr_commit_i = 0; busy_i = 0; addr_i = 0;
        tick(); tick(); rst = 0; #1;

        // R1 reset state
        chk("R1 status after reset", status_o, 8'h00);
        chk("R1 array flag after reset", arr_wr_ok_o, 0);
        chk("R1 status flag after reset", sr_wr_ok_o, 0);

        for (int pe = 0; pe < 2; pe++) begin
            for (int code = 0; code < 4; code++) begin
                for (int lvl = 0; lvl < 2; lvl++) begin
                    logic [7:0] nvexp;
                    int         srexp;
                    nvexp = {pe[0], 3'b000, code[1:0], 2'b00};
                    // R6 load, spare data bits dropped, latch cleared
                    pulse_wren();
                    pulse_sample(1'b1);
                    pulse_sr({pe[0], 3'b111, code[1:0], 2'b11});
                    chk("R6 status after commit", status_o, nvexp);
                    // R3 latch off blocks writes
                    addr_i = 0; #1;
                    chk("R3 array flag latch off", arr_wr_ok_o, 0);
                    chk("R3 status flag latch off", sr_wr_ok_o, 0);
                    // R2 set latch
                    pulse_wren();
                    chk("R2 latch bit set", status_o, nvexp | 8'h02);
                    // R4 sampled pin decides
                    pulse_sample(lvl[0]);
                    srexp = (pe == 0 || lvl == 1) ? 1 : 0;
                    chk("R4 status permission", sr_wr_ok_o, srexp);
                    wp_pin_i = ~lvl[0]; #1;
                    chk("R4 late pin change ignored", sr_wr_ok_o, srexp);
                    // R5 every page
                    for (int pg = 0; pg < 256; pg++) begin
                        addr_i = AW'(pg * 32 + (pg % 32)); #1;
                        chk("R5 array permission", arr_wr_ok_o,
                            expect_arr(code, pg * 32 + (pg % 32)));
                    end
                    // R8 busy view
                    busy_i = 1; #1;
                    chk("R8 busy status view", status_o, 8'hFF);
                    chk("R8 busy array flag", arr_wr_ok_o, 0);
                    chk("R4 busy status flag", sr_wr_ok_o, 0);
                    busy_i = 0; #1;
                    // R7 array commit drops latch, keeps bits
                    arr_commit_i = 1; tick(); arr_commit_i = 0; #1;
                    chk("R7 array commit status", status_o, nvexp);
                end
            end
        end

        // R2 clear and priority cases
        pulse_sr(8'h00);
        pulse_wren();
        pulse_wrdi();
        chk("R2 wrdi clears", status_o, 8'h00);
        wren_i = 1; wrdi_i = 1; tick(); wren_i = 0; wrdi_i = 0; #1;
        chk("R2 clear wins over set", status_o, 8'h00);
        busy_i = 1; pulse_wren(); busy_i = 0; #1;
        chk("R2 set ignored while busy", status_o, 8'h00);
        wren_i = 1; arr_commit_i = 1; tick(); wren_i = 0; arr_commit_i = 0; #1;
        chk("R7 commit wins over set", status_o, 8'h00);
        // R6 nothing changes without commit
        pulse_wren(); sr_data_i = 8'h8C; tick(); tick(); sr_data_i = 0; #1;
        chk("R6 no change without commit", status_o, 8'h02);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule